// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Frame Encoder

This block turns a stream of stereo audio samples into a single serial line carrying biphase-mark coded digital audio frames. It runs from a half-cell clock at 128 times the sample rate. Every clock puts one half-cell on the line. A frame holds two subframes, left first and then right. Each subframe has 32 logical slots and every slot lasts two half-cells. Each subframe opens with a sync preamble that deliberately breaks the coding rule. After the preamble come the audio payload and four trailing flags: validity, user data, one channel-status bit and an even-parity bit.

Audio enters through a one-deep holding register with a valid/ready handshake. At most one left/right pair is taken per frame. Three configuration inputs set the channel-status block for each run of 192 frames: consumer or professional format, the pre-emphasis flag and the sample-rate code. The same format setting selects a 20-bit payload (consumer) or a 24-bit payload (professional). The status block is precomputed into a 192-bit table at each block boundary. Coding works on 8-slot chunks. A computed 256-entry mapping turns each chunk into 16 half-cells, and the whole pattern is inverted when the line is currently high.

Top module: `spdif_bmc_tx`

## Requirements
- R1: `line_out` changes level at the start of every slot from 4 to 31. It changes again in the middle of the slot exactly when that slot's bit is 1. Half-cells go out one per clock, 128 per frame, left subframe first.
- R2: Each subframe begins with 8 preamble half-cells, listed first to last and referred to a low line before them. The left subframe of frame 0 of a block sends 11101000, every other left subframe sends 11100010, and a right subframe sends 11100100.
- R3: Slots 4 to 27 carry audio with the LSB in slot 4. Slot 28 is validity, slot 29 is user data (always 0), slot 30 is channel status and slot 31 makes the count of 1s in slots 4 to 31 even, so every subframe ends with the line low.
- R4: In consumer format, input bits 23..4 go into slots 8 to 27 and slots 4 to 7 are 0. In professional format, all 24 input bits go into slots 4 to 27.
- R5: `in_ready` is high while the holding register is empty. A pair is taken on a clock where `in_valid` and `in_ready` are both high, and accepted pairs go out in acceptance order, one per frame.
- R6: A frame that starts while the holding register is empty carries zero audio with validity 1 in both subframes. A frame built from an accepted pair carries validity 0.
- R7: A block is 192 frames. Frame n of a block carries status bit n in slot 30 of both subframes.
- R8: Status bit map, with every bit not named here equal to 0. Consumer format: bit 0 = 0 and bit 3 = pre-emphasis. Its rate code in bits 24..27 is 0000 for 44.1 kHz, 0100 for 48 kHz and 0101 for 96 kHz, written bit 24 first. Professional format: bits 0 and 2 = 1 and bit 3 = pre-emphasis. Bits 6,7 are 1,0 for 44.1 kHz, 0,1 for 48 kHz and 0,0 for 96 kHz. `cfg_rate` encodes 00 = 44.1, 01 = 48 and 1x = 96 kHz.
- R9: The format, pre-emphasis and rate inputs are sampled only when frame 0 of a block is loaded. A change in mid-block affects neither the payload width nor the status bits until the next block.
- R10: During reset `line_out` is low and `in_ready` is high. The first frame after reset is frame 0 of a block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cell clock, 128 × sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | Holding register empty, pair will be taken |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| cfg_pro | input | 1 | 1 = professional status and 24-bit payload |
| cfg_preemph | input | 1 | Pre-emphasis flag for the status block |
| cfg_rate | input | 2 | Sample-rate code for the status block |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
If the half-cell counter slips, the next preamble lands on a wrong half-cell. The result is either a missing slot-start transition or a subframe that does not end low, and both show up within one subframe of 64 clocks. A wrong line-level memory used for chunk inversion shows up as a missing transition at the very next 16-half-cell chunk boundary. A corrupted frame index or status table shows only in the slot-30 bits, so it becomes visible when a frame whose status bit is non-zero is sent, or at the misplaced block preamble, up to 192 frames later. A holding register that loses or repeats a pair gives a payload mismatch, or a validity flag that is wrong, in the very next frame.

// File: rtl/spdif_bmc_pkg.sv
package spdif_bmc_pkg;

  parameter int unsigned AUD_W     = 24;
  parameter int unsigned CONS_W    = 20;
  parameter int unsigned SLOTS     = 32;
  parameter int unsigned BLOCK_LEN = 192;

  localparam int unsigned HALF_PER_SUB   = 2 * SLOTS;
  localparam int unsigned HALF_PER_FRAME = 2 * HALF_PER_SUB;
  localparam int unsigned CNT_W          = $clog2(HALF_PER_FRAME);
  localparam int unsigned CHUNK_BITS     = 8;
  localparam int unsigned CHUNK_HALVES   = 2 * CHUNK_BITS;
  localparam int unsigned CHUNK_LSB      = $clog2(CHUNK_HALVES);
  localparam int unsigned CHUNK_SEL_W    = $clog2(SLOTS / CHUNK_BITS);
  localparam int unsigned FR_W           = $clog2(BLOCK_LEN);
  localparam int unsigned PRE_SLOTS      = 4;

  localparam int unsigned SLOT_AUD = PRE_SLOTS;
  localparam int unsigned SLOT_V   = SLOT_AUD + AUD_W;
  localparam int unsigned SLOT_U   = SLOT_V + 1;
  localparam int unsigned SLOT_C   = SLOT_U + 1;
  localparam int unsigned SLOT_P   = SLOT_C + 1;

  // sync patterns, first half-cell in the MSB, referred to a low line
  localparam logic [2*PRE_SLOTS-1:0] SYNC_BLOCK = 8'b1110_1000;
  localparam logic [2*PRE_SLOTS-1:0] SYNC_LEFT  = 8'b1110_0010;
  localparam logic [2*PRE_SLOTS-1:0] SYNC_RIGHT = 8'b1110_0100;

  typedef logic [SLOTS-1:0]         sub_word_t;
  typedef logic [CHUNK_HALVES-1:0]  chunk_pat_t;
  typedef logic [BLOCK_LEN-1:0]     status_blk_t;

  typedef struct packed {
    logic [AUD_W-1:0] left;
    logic [AUD_W-1:0] right;
    logic             invalid;
  } frame_t;

  // 8 slots -> 16 half-cells, assuming the line was low before; bit 0 goes first
  function automatic chunk_pat_t bmc_chunk(input logic [CHUNK_BITS-1:0] bits);
    chunk_pat_t p;
    logic       lvl;
    lvl = 1'b0;
    p   = '0;
    for (int i = 0; i < CHUNK_BITS; i++) begin
      lvl = ~lvl;
      p[CHUNK_HALVES-1-2*i] = lvl;
      if (bits[i]) lvl = ~lvl;
      p[CHUNK_HALVES-2-2*i] = lvl;
    end
    return p;
  endfunction

  function automatic sub_word_t build_sub(input logic [AUD_W-1:0] smp, input logic pro,
                                          input logic invalid, input logic cs_bit);
    sub_word_t        w;
    logic [AUD_W-1:0] pay;
    pay = smp;
    if (!pro) pay[AUD_W-CONS_W-1:0] = '0;
    w = '0;
    w[SLOT_AUD +: AUD_W] = pay;
    w[SLOT_V] = invalid;
    w[SLOT_U] = 1'b0;
    w[SLOT_C] = cs_bit;
    w[SLOT_P] = ^w[SLOT_P-1:SLOT_AUD];
    return w;
  endfunction

  // rate code: 00 = 44.1 kHz, 01 = 48 kHz, 1x = 96 kHz
  function automatic status_blk_t build_status(input logic pro, input logic pre,
                                               input logic [1:0] rate);
    status_blk_t cs;
    cs = '0;
    cs[3] = pre;
    if (pro) begin
      cs[0] = 1'b1;
      cs[2] = 1'b1;
      if (!rate[1]) begin
        cs[6] = ~rate[0];
        cs[7] = rate[0];
      end
    end else begin
      cs[25] = rate[1] | rate[0];
      cs[27] = rate[1];
    end
    return cs;
  endfunction

endpackage

// File: rtl/spdif_frame_src.sv
module spdif_frame_src
  import spdif_bmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [AUD_W-1:0]     in_left,
  input  logic [AUD_W-1:0]     in_right,
  input  logic                 cfg_pro,
  input  logic                 cfg_preemph,
  input  logic [1:0]           cfg_rate,
  output logic [CNT_W-1:0]     cnt,
  output logic                 block_head,
  output sub_word_t            word_l,
  output sub_word_t            word_r
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PER_FRAME - 1);
  localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(BLOCK_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [FR_W-1:0]  fr_q;
  logic             hold_full;
  logic [AUD_W-1:0] hold_l, hold_r;
  frame_t           frm_q;
  status_blk_t      cs_q;
  logic             pro_q;

  logic accept, frame_load, block_load;

  assign in_ready   = ~hold_full;
  assign accept     = in_valid & ~hold_full;
  assign frame_load = (cnt_q == CNT_LAST);
  assign block_load = frame_load & (fr_q == FR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= CNT_LAST;
      fr_q      <= FR_LAST;
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      frm_q     <= '{left: '0, right: '0, invalid: 1'b1};
      cs_q      <= '0;
      pro_q     <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (accept) begin
        hold_l <= in_left;
        hold_r <= in_right;
      end
      if (frame_load) begin
        hold_full <= accept;
        fr_q      <= block_load ? '0 : fr_q + 1'b1;
        if (hold_full) frm_q <= '{left: hold_l, right: hold_r, invalid: 1'b0};
        else           frm_q <= '{left: '0, right: '0, invalid: 1'b1};
      end else if (accept) begin
        hold_full <= 1'b1;
      end
      if (block_load) begin
        cs_q  <= build_status(cfg_pro, cfg_preemph, cfg_rate);
        pro_q <= cfg_pro;
      end
    end
  end

  assign cnt        = cnt_q;
  assign block_head = (fr_q == '0);
  assign word_l     = build_sub(frm_q.left,  pro_q, frm_q.invalid, cs_q[fr_q]);
  assign word_r     = build_sub(frm_q.right, pro_q, frm_q.invalid, cs_q[fr_q]);

endmodule

// File: rtl/spdif_chunk_coder.sv
module spdif_chunk_coder
  import spdif_bmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             block_head,
  input  sub_word_t        word_l,
  input  sub_word_t        word_r,
  output logic             line_out
);

  logic                       chunk_start, right_sub;
  logic [CHUNK_SEL_W-1:0]     chunk_sel;
  sub_word_t                  word;
  logic [CHUNK_BITS-1:0]      chunk_bits;
  logic [2*PRE_SLOTS-1:0]     sync;
  chunk_pat_t                 enc_full, enc_tail, raw, pat;
  chunk_pat_t                 sh_q;
  logic                       line_q;

  assign chunk_start = (cnt[CHUNK_LSB-1:0] == '0);
  assign chunk_sel   = cnt[CHUNK_LSB +: CHUNK_SEL_W];
  assign right_sub   = cnt[CNT_W-1];

  always_comb begin
    word       = right_sub ? word_r : word_l;
    chunk_bits = word[chunk_sel*CHUNK_BITS +: CHUNK_BITS];
    sync       = right_sub ? SYNC_RIGHT : (block_head ? SYNC_BLOCK : SYNC_LEFT);
    enc_full   = bmc_chunk(chunk_bits);
    enc_tail   = bmc_chunk({chunk_bits[CHUNK_BITS-1:PRE_SLOTS], PRE_SLOTS'(0)});
    raw        = (chunk_sel == '0) ? {sync, enc_tail[2*PRE_SLOTS-1:0]} : enc_full;
    pat        = raw ^ {CHUNK_HALVES{line_q}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      sh_q   <= '0;
    end else if (chunk_start) begin
      line_q <= pat[CHUNK_HALVES-1];
      sh_q   <= {pat[CHUNK_HALVES-2:0], 1'b0};
    end else begin
      line_q <= sh_q[CHUNK_HALVES-1];
      sh_q   <= {sh_q[CHUNK_HALVES-2:0], 1'b0};
    end
  end

  assign line_out = line_q;

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
  import spdif_bmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AUD_W-1:0] in_left,
  input  logic [AUD_W-1:0] in_right,
  input  logic             cfg_pro,
  input  logic             cfg_preemph,
  input  logic [1:0]       cfg_rate,
  output logic             line_out
);

  logic [CNT_W-1:0] cnt;
  logic             block_head;
  sub_word_t        word_l, word_r;

  spdif_frame_src u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_left    (in_left),
    .in_right   (in_right),
    .cfg_pro    (cfg_pro),
    .cfg_preemph(cfg_preemph),
    .cfg_rate   (cfg_rate),
    .cnt        (cnt),
    .block_head (block_head),
    .word_l     (word_l),
    .word_r     (word_r)
  );

  spdif_chunk_coder u_coder (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .block_head(block_head),
    .word_l    (word_l),
    .word_r    (word_r),
    .line_out  (line_out)
  );

endmodule

// File: rtl/spdif_bmc_tx_chk.sv
module spdif_bmc_tx_chk
  import spdif_bmc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             line_out,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PER_FRAME - 1);

  assert_slot_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt[0] && (cnt[CNT_W-2:1] >= PRE_SLOTS)) |=> (line_out != $past(line_out)));

  assert_sync_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[CNT_W-2:0] == '0) |=> (line_out != $past(line_out)));

  assert_sub_ends_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[CNT_W-2:0] == '1) |=> !line_out);

  assert_hold_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_hold_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == CNT_LAST) && !(in_valid && in_ready)) |=> in_ready);

endmodule

bind spdif_bmc_tx spdif_bmc_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .line_out(line_out),
  .cnt     (cnt)
);

// File: tb/test_spdif_bmc_tx.sv
module test_spdif_bmc_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0, in_right = '0;
  logic        cfg_pro = 1'b0, cfg_preemph = 1'b0;
  logic [1:0]  cfg_rate = 2'b01;
  logic        line_out;

  int n_vec = 0, n_bad = 0;
  int mon_frame = 0, idle_frames = 0;
  logic [47:0] q[$];
  logic [127:0] hc;
  logic prev_end = 1'b0;
  bit done = 0;

  // per-block configuration applied by the driver
  bit       bc_pro [3] = '{0, 1, 0};
  bit       bc_pre [3] = '{0, 1, 1};
  logic [1:0] bc_rate [3] = '{2'b01, 2'b10, 2'b00};

  always #5 clk = ~clk;

  spdif_bmc_tx i_spdif_bmc_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .cfg_pro(cfg_pro),
    .cfg_preemph(cfg_preemph), .cfg_rate(cfg_rate), .line_out(line_out)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (frame %0d): got %h expected %h", tag, mon_frame, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // status bit n expected from the R8 map
  function automatic bit exp_cs(input int n, input bit pro, input bit pre, input logic [1:0] rate);
    case (n)
      0, 2:    return pro;
      3:       return pre;
      6:       return pro && (rate == 2'b00);
      7:       return pro && (rate == 2'b01);
      25:      return !pro && (rate != 2'b00);
      27:      return !pro && rate[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic decode_frame();
    logic [31:0] w [2];
    int blk = (mon_frame / 192 > 2) ? 2 : mon_frame / 192;
    int idx = mon_frame % 192;
    bit late0 = (blk == 0) && (idx >= 110);
    bit pro = bc_pro[blk];
    logic [47:0] e;
    logic [23:0] el, er;
    string tag;
    for (int sf = 0; sf < 2; sf++) begin
      int base = sf * 64;
      logic [7:0] got_pre, exp_pre;
      bit edges_ok = 1;
      logic prev;
      prev = (sf == 0) ? prev_end : hc[63];
      check(prev == 1'b0, "R3 line low before preamble", 48'(prev), 48'h0);
      for (int j = 0; j < 8; j++) got_pre[7-j] = hc[base+j];
      exp_pre = (sf == 1) ? 8'b11100100 : ((idx == 0) ? 8'b11101000 : 8'b11100010);
      tag = (sf == 0 && mon_frame == 0) ? "R10 first frame is block start" : "R2 preamble";
      check(got_pre == exp_pre, tag, 48'(got_pre), 48'(exp_pre));
      w[sf] = '0;
      for (int s = 4; s < 32; s++) begin
        if (hc[base+2*s] == hc[base+2*s-1]) edges_ok = 0;
        w[sf][s] = hc[base+2*s] ^ hc[base+2*s+1];
      end
      check(edges_ok, "R1 slot-start transitions", 48'(edges_ok), 48'h1);
      check(^w[sf][31:4] == 1'b0, "R3 even parity", 48'(w[sf]), 48'h0);
      check(w[sf][29] == 1'b0, "R3 user bit", 48'(w[sf][29]), 48'h0);
      if (late0) tag = "R9 status held to block start";
      else if (idx inside {0, 2, 3, 6, 7, 25, 27}) tag = "R8 status bit map";
      else tag = "R7 status stream";
      check(w[sf][30] == exp_cs(idx, pro, bc_pre[blk], bc_rate[blk]), tag,
            48'(w[sf][30]), 48'(exp_cs(idx, pro, bc_pre[blk], bc_rate[blk])));
    end
    check(w[0][28] == w[1][28], "R6 validity equal in both subframes", 48'(w[1][28]), 48'(w[0][28]));
    if (w[0][28]) begin
      idle_frames++;
      check(w[0][27:4] == 24'h0 && w[1][27:4] == 24'h0, "R6 idle frame audio zero",
            {w[0][27:4], w[1][27:4]}, 48'h0);
    end else if (q.size() == 0) begin
      check(1'b0, "R5 frame without accepted sample", 48'(w[0][27:4]), 48'h0);
    end else begin
      e  = q.pop_front();
      el = pro ? e[47:24] : {e[47:28], 4'h0};
      er = pro ? e[23:0]  : {e[23:4], 4'h0};
      tag = late0 ? "R9 payload width held" : "R4 left payload";
      check(w[0][27:4] == el, tag, 48'(w[0][27:4]), 48'(el));
      check(w[1][27:4] == er, "R5 right payload in order", 48'(w[1][27:4]), 48'(er));
    end
    prev_end = hc[127];
  endtask

  // monitor: collect 128 half-cells per frame, decode, compare with the queue
  initial begin : monitor
    wait (rst_n);
    @(posedge clk);
    @(negedge clk);
    forever begin
      for (int i = 0; i < 128; i++) begin
        @(negedge clk);
        hc[i] = line_out;
      end
      decode_frame();
      mon_frame++;
    end
  end

  task automatic send(input logic [23:0] l, input logic [23:0] r);
    in_valid = 1'b1;
    in_left  = l;
    in_right = r;
    while (!in_ready) @(negedge clk);
    q.push_back({l, r});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : driver
    int stage = 0;
    int k = 0;
    logic [23:0] l, r;
    cfg_pro = bc_pro[0]; cfg_preemph = bc_pre[0]; cfg_rate = bc_rate[0];
    repeat (4) @(negedge clk);
    check(line_out == 1'b0, "R10 line low in reset", 48'(line_out), 48'h0);
    check(in_ready == 1'b1, "R10 ready high in reset", 48'(in_ready), 48'h1);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    while (mon_frame < 580) begin
      if (k == 60) repeat (400) @(negedge clk);
      if (stage == 0 && mon_frame >= 100) begin
        cfg_pro = bc_pro[1]; cfg_preemph = bc_pre[1]; cfg_rate = bc_rate[1]; stage = 1;
      end
      if (stage == 1 && mon_frame >= 300) begin
        cfg_pro = bc_pro[2]; cfg_preemph = bc_pre[2]; cfg_rate = bc_rate[2]; stage = 2;
      end
      case (k % 5)
        0: begin l = 24'hFFFFFF; r = 24'h000001; end
        1: begin l = 24'h800000; r = 24'h7FFFFF; end
        default: begin
          l = 24'(k * 32'h00A3C5B7) ^ 24'h5A5A5A;
          r = ~l + 24'(k);
        end
      endcase
      send(l, r);
      k++;
    end
    check(idle_frames >= 2, "R6 idle frames observed", 48'(idle_frames), 48'h2);
    check(q.size() <= 3, "R5 accepted pairs all transmitted", 48'(q.size()), 48'h3);
    finish_run();
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
    end
  end

endmodule